// File: doc/BRIEF.md
# UART Channel Command Decoder

This block sits between a host register write port and the control inputs of one UART channel. The host writes one command byte, and the byte carries two kinds of request. The first is a single encoded action in a three-bit field: a pointer reset, a receiver or transmitter reset, a status clear, or a break request. The second is four independent bits that switch the receiver and the transmitter on or off. The decoder turns the encoded action into one-clock strobes for the receiver, transmitter, status and interrupt logic. It keeps the two enable flags and the mode-register pointer as persistent state.

Every part of a write takes effect on the same clock edge. The enable flags and all strobes become visible in the cycle after the write is sampled. When a write asks for opposite things in the same direction, the request that turns the engine off wins. A break start is only passed on if the transmitter is enabled once the write has been applied. When the receiver is turned on outside wake-up mode, the decoder also sends a strobe that tells the receiver to search for a start bit.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `rx_en_o` and `tx_en_o` are 0, every strobe output is 0, and `mr_sel_o` is 0 (first mode register).
- R2: On a write, field `wr_data[6:4]` selects one action, with code values 0 none, 1 pointer reset, 2 receiver reset, 3 transmitter reset, 4 error clear, 5 break-change clear, 6 break start and 7 break stop. The matching strobe goes high for exactly one clock, in the cycle after the write, and at most one of these strobes is high at a time.
- R3: Bit 2 of a written byte sets `tx_en_o` and bit 0 sets `rx_en_o`, from the cycle after the write.
- R4: Bit 3 clears `tx_en_o` and bit 1 clears `rx_en_o`. If the enable and disable bits for one direction are both set, the flag ends up 0.
- R5: Code 2 clears `rx_en_o` and code 3 clears `tx_en_o`, even when the same write sets the matching enable bit.
- R6: `rx_hunt_o` pulses for one clock after a write that turns the receiver on (bit 0 set, bit 1 clear, code not 2) while `wake_mode_i` is 0. It stays low when `wake_mode_i` is 1.
- R7: Code 6 raises `brk_start_o` only if `tx_en_o` is 1 after the write has been applied. Otherwise the break start is dropped.
- R8: Bit 7 of the byte has no effect. A cycle with `wr_en_i` low changes no flag and raises no strobe.
- R9: `mr_sel_o` moves from 0 to 1 after an `mr_acc_i` cycle. Code 1 returns it to 0, and code 1 takes priority over an access in the same cycle.
- R10: The encoded action and the enable and disable bits of one write are all applied on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe for the command byte |
| wr_data_i | input | 8 | Command byte |
| wake_mode_i | input | 1 | Receiver is in wake-up mode |
| mr_acc_i | input | 1 | A mode-register access took place this cycle |
| rx_en_o | output | 1 | Receiver enable flag |
| tx_en_o | output | 1 | Transmitter enable flag |
| mr_sel_o | output | 1 | Mode-register pointer, 0 first, 1 second |
| mr_ptr_rst_o | output | 1 | Pointer-reset strobe |
| rx_reset_o | output | 1 | Receiver reset and FIFO flush strobe |
| tx_reset_o | output | 1 | Transmitter reset strobe |
| err_clr_o | output | 1 | Clear break, framing, parity and overrun status |
| brk_chg_clr_o | output | 1 | Clear break-change interrupt strobe |
| brk_start_o | output | 1 | Start-break request strobe |
| brk_stop_o | output | 1 | Stop-break request strobe |
| rx_hunt_o | output | 1 | Send the receiver to search for a start bit |

## Verification
The bench builds the block with its default parameters: an 8-bit byte with the action field at bits 6:4. Every one of the eight code values, and every control-bit position, therefore appears on the port exactly where the host would place it. Each write in the vector table is followed by an idle cycle, which shows that every strobe lasts one clock and that the flags hold. The table reaches the corner cases where the rules meet: enable and disable in one write, a reset combined with an enable, and a break start in the same write as a transmitter enable or with the transmitter off.

// File: rtl/uart_cmd_pkg.sv
// Package: shared encodings for the channel command decoder.
// Assumes the action field is three bits wide and holds the codes below.
package uart_cmd_pkg;
    localparam int CMD_W = 3;
    localparam int NCMD  = 2 ** CMD_W;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE      = 3'd0,
        CMD_MR_RST    = 3'd1,
        CMD_RX_RST    = 3'd2,
        CMD_TX_RST    = 3'd3,
        CMD_ERR_CLR   = 3'd4,
        CMD_BRK_CLR   = 3'd5,
        CMD_BRK_START = 3'd6,
        CMD_BRK_STOP  = 3'd7
    } cmd_e;

    // Direction indices used for the enable-flag array
    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;
    localparam int NDIR   = 2;
endpackage

// File: rtl/cmd_field_decode.sv
// Module: turns the encoded action field into a one-hot vector.
// Assumes valid is the host write strobe. When it is low, the output is all zero.
module cmd_field_decode #(
    parameter int CODE_W = 3,
    localparam int NOUT  = 2 ** CODE_W
) (
    input  logic              valid,
    input  logic [CODE_W-1:0] code,
    output logic [NOUT-1:0]   hot
);
    // One comparator per code value
    for (genvar i = 0; i < NOUT; i++) begin : g_hot
        assign hot[i] = valid && (code == CODE_W'(i));
    end
endmodule

// File: rtl/dir_enable.sv
// Module: persistent enable flag for one direction (receiver or transmitter).
// Assumes the off requests (disable bit, reset command) win over the enable bit.
// Also exports the value the flag takes on the next edge.
module dir_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic en_req,
    input  logic dis_req,
    input  logic force_off,
    output logic en_nxt_o,
    output logic en_o
);
    logic en_q;

    // Next-state rule: an off request beats the enable bit
    always_comb begin
        en_nxt_o = en_q;
        if (wr) begin
            if (dis_req || force_off) en_nxt_o = 1'b0;
            else if (en_req)          en_nxt_o = 1'b1;
        end
    end

    // Flag register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_nxt_o;
    end

    assign en_o = en_q;

    // R4
    dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && dis_req) |=> !en_o);
    // R5
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && force_off) |=> !en_o);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && rst_n) |=> $stable(en_o));
endmodule

// File: rtl/mr_ptr.sv
// Module: mode-register pointer. It starts at the first register and moves to
// the second after one access. The reset command returns it to the first.
// Assumes the reset command takes priority over an access in the same cycle.
module mr_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic ptr_rst,
    input  logic acc,
    output logic sel_o
);
    logic sel_q;

    // Pointer update: the reset command first, then an access
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= 1'b0;
        else if (ptr_rst) sel_q <= 1'b0;
        else if (acc)     sel_q <= 1'b1;
    end

    assign sel_o = sel_q;

    // R9
    ptr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> !sel_o);
    // R9
    ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ptr_rst) |=> sel_o);
endmodule

// File: rtl/uart_cmd_ctrl.sv
// Module: command decoder for one UART channel.
// It decodes a host byte into one-clock strobes and the persistent enable state.
// Assumes byte layout: bit 7 unused, bits 6:4 action code, bit 3 transmitter
// off, bit 2 transmitter on, bit 1 receiver off, bit 0 receiver on.
// All strobes and flags are registered, so they show in the cycle after the write.
module uart_cmd_ctrl
    import uart_cmd_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CMD_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wake_mode_i,
    input  logic              mr_acc_i,
    output logic              rx_en_o,
    output logic              tx_en_o,
    output logic              mr_sel_o,
    output logic              mr_ptr_rst_o,
    output logic              rx_reset_o,
    output logic              tx_reset_o,
    output logic              err_clr_o,
    output logic              brk_chg_clr_o,
    output logic              brk_start_o,
    output logic              brk_stop_o,
    output logic              rx_hunt_o
);
    localparam int CMD_MSB  = CMD_LSB + CMD_W - 1;
    localparam int RX_ON_B  = 0;
    localparam int RX_OFF_B = 1;
    localparam int TX_ON_B  = 2;
    localparam int TX_OFF_B = 3;

    logic [NCMD-1:0] hot;
    logic [NDIR-1:0] en_req, dis_req, force_off, en_nxt, en_cur;
    logic            hunt_d;
    logic [NCMD-1:1] strobe_d, strobe_q;
    logic            rsvd_unused;

    // Bit 7 and the "none" code drive nothing
    assign rsvd_unused = wr_data_i[DATA_W-1] ^ hot[CMD_NONE];

    cmd_field_decode #(.CODE_W(CMD_W)) i_dec (
        .valid (wr_en_i),
        .code  (wr_data_i[CMD_MSB:CMD_LSB]),
        .hot   (hot)
    );

    // Per-direction request bits taken from the byte
    assign en_req[DIR_RX]    = wr_data_i[RX_ON_B];
    assign dis_req[DIR_RX]   = wr_data_i[RX_OFF_B];
    assign force_off[DIR_RX] = hot[CMD_RX_RST];
    assign en_req[DIR_TX]    = wr_data_i[TX_ON_B];
    assign dis_req[DIR_TX]   = wr_data_i[TX_OFF_B];
    assign force_off[DIR_TX] = hot[CMD_TX_RST];

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        dir_enable i_en (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr_en_i),
            .en_req    (en_req[d]),
            .dis_req   (dis_req[d]),
            .force_off (force_off[d]),
            .en_nxt_o  (en_nxt[d]),
            .en_o      (en_cur[d])
        );
    end

    mr_ptr i_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_rst (hot[CMD_MR_RST]),
        .acc     (mr_acc_i),
        .sel_o   (mr_sel_o)
    );

    // Strobe inputs: a break start needs the transmitter on after this write
    always_comb begin
        strobe_d = hot[NCMD-1:1];
        strobe_d[CMD_BRK_START] = hot[CMD_BRK_START] && en_nxt[DIR_TX];
    end

    // Receiver start-bit search request when it is switched on outside wake-up mode
    assign hunt_d = wr_en_i && en_req[DIR_RX] && !dis_req[DIR_RX]
                    && !force_off[DIR_RX] && !wake_mode_i;

    // Strobe registers: each high for the one cycle after the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q  <= '0;
            rx_hunt_o <= 1'b0;
        end else begin
            strobe_q  <= strobe_d;
            rx_hunt_o <= hunt_d;
        end
    end

    assign rx_en_o       = en_cur[DIR_RX];
    assign tx_en_o       = en_cur[DIR_TX];
    assign mr_ptr_rst_o  = strobe_q[CMD_MR_RST];
    assign rx_reset_o    = strobe_q[CMD_RX_RST];
    assign tx_reset_o    = strobe_q[CMD_TX_RST];
    assign err_clr_o     = strobe_q[CMD_ERR_CLR];
    assign brk_chg_clr_o = strobe_q[CMD_BRK_CLR];
    assign brk_start_o   = strobe_q[CMD_BRK_START];
    assign brk_stop_o    = strobe_q[CMD_BRK_STOP];

    // R2
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_q));
    // R2
    strobe_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q != '0) |-> $past(wr_en_i));
    // R7
    brk_start_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start_o |-> tx_en_o);
    // R5
    rx_reset_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset_o |-> !rx_en_o);
    // R5
    tx_reset_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset_o |-> !tx_en_o);
    // R6
    hunt_rx_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hunt_o |-> (rx_en_o && !$past(wake_mode_i)));
endmodule

// File: tb/test_uart_cmd_ctrl.sv
module test_uart_cmd_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wake = 1'b0;
    logic       mr_acc = 1'b0;
    logic       rx_en, tx_en, mr_sel;
    logic       mr_ptr_rst, rx_reset, tx_reset, err_clr, brk_chg_clr;
    logic       brk_start, brk_stop, rx_hunt;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    uart_cmd_ctrl i_uart_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .wake_mode_i(wake), .mr_acc_i(mr_acc),
        .rx_en_o(rx_en), .tx_en_o(tx_en), .mr_sel_o(mr_sel),
        .mr_ptr_rst_o(mr_ptr_rst), .rx_reset_o(rx_reset), .tx_reset_o(tx_reset),
        .err_clr_o(err_clr), .brk_chg_clr_o(brk_chg_clr),
        .brk_start_o(brk_start), .brk_stop_o(brk_stop), .rx_hunt_o(rx_hunt)
    );

    // Pulse order: hunt, stop, start, brkclr, errclr, txrst, rxrst, mrrst
    function automatic logic [7:0] pulses();
        return {rx_hunt, brk_stop, brk_start, brk_chg_clr,
                err_clr, tx_reset, rx_reset, mr_ptr_rst};
    endfunction

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Row: {byte, wake, exp rx_en, exp tx_en, exp pulses}
    localparam logic [18:0] VEC [20] = '{
        {8'h00, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 code none
        {8'h01, 1'b0, 1'b1, 1'b0, 8'h80},  // R3 R6 rx on, hunt
        {8'h04, 1'b0, 1'b1, 1'b1, 8'h00},  // R3 tx on
        {8'h60, 1'b0, 1'b1, 1'b1, 8'h20},  // R2 R7 break start, tx on
        {8'h70, 1'b0, 1'b1, 1'b1, 8'h40},  // R2 break stop
        {8'h40, 1'b0, 1'b1, 1'b1, 8'h08},  // R2 error clear
        {8'h50, 1'b0, 1'b1, 1'b1, 8'h10},  // R2 break-change clear
        {8'h10, 1'b0, 1'b1, 1'b1, 8'h01},  // R2 pointer reset
        {8'h0C, 1'b0, 1'b1, 1'b0, 8'h00},  // R4 tx on+off -> off
        {8'h60, 1'b0, 1'b1, 1'b0, 8'h00},  // R7 break start dropped
        {8'h03, 1'b0, 1'b0, 1'b0, 8'h00},  // R4 R6 rx on+off -> off, no hunt
        {8'h01, 1'b1, 1'b1, 1'b0, 8'h00},  // R6 wake mode: no hunt
        {8'h20, 1'b0, 1'b0, 1'b0, 8'h02},  // R5 receiver reset
        {8'h05, 1'b0, 1'b1, 1'b1, 8'h80},  // R3 both on
        {8'h30, 1'b0, 1'b1, 1'b0, 8'h04},  // R5 transmitter reset
        {8'h80, 1'b0, 1'b1, 1'b0, 8'h00},  // R8 bit 7 alone
        {8'h64, 1'b0, 1'b1, 1'b1, 8'h20},  // R7 R10 tx on with break start
        {8'h21, 1'b0, 1'b0, 1'b1, 8'h02},  // R5 R10 reset beats rx on
        {8'h09, 1'b0, 1'b1, 1'b0, 8'h80},  // R10 tx off, rx on
        {8'hF6, 1'b0, 1'b0, 1'b1, 8'h40}   // R8 R10 bit7, stop, tx on, rx off
    };

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1 reset", {rx_en, tx_en, pulses()}, 10'h000);
        check("R1 pointer", {9'd0, mr_sel}, 10'h000);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            wr_data = VEC[i][18:11];
            wake    = VEC[i][10];
            wr_en   = 1'b1;
            @(negedge clk);
            wr_en = 1'b0;
            check($sformatf("vector %0d R2 R3 R4 R5 R6 R7 R8 R10", i),
                  {rx_en, tx_en, pulses()}, VEC[i][9:0]);
            @(negedge clk);
            // R2: one-clock strobes, flags held
            check($sformatf("vector %0d idle R2", i),
                  {rx_en, tx_en, pulses()}, {VEC[i][9:8], 8'h00});
        end

        // R8: no write, data bits present
        wr_data = 8'h35;
        wake    = 1'b0;
        @(negedge clk);
        check("R8 no write", {rx_en, tx_en, pulses()}, {2'b01, 8'h00});

        // R9: pointer moves after an access
        mr_acc = 1'b1;
        @(negedge clk);
        mr_acc = 1'b0;
        check("R9 advance", {9'd0, mr_sel}, 10'h001);
        @(negedge clk);
        check("R9 stays", {9'd0, mr_sel}, 10'h001);
        // R9: pointer reset command
        wr_data = 8'h10;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 reset cmd", {mr_ptr_rst, 8'd0, mr_sel}, 10'h200);
        // R9: pointer reset beats access in the same cycle
        mr_acc = 1'b1;
        @(negedge clk);
        mr_acc = 1'b0;
        check("R9 access", {9'd0, mr_sel}, 10'h001);
        wr_en  = 1'b1;
        mr_acc = 1'b1;
        @(negedge clk);
        wr_en  = 1'b0;
        mr_acc = 1'b0;
        check("R9 priority", {9'd0, mr_sel}, 10'h000);

        // R1: reset mid-run clears the state
        wr_data = 8'h05;
        wr_en   = 1'b1;
        mr_acc  = 1'b1;
        @(negedge clk);
        wr_en  = 1'b0;
        mr_acc = 1'b0;
        rst_n  = 1'b0;
        @(negedge clk);
        check("R1 reset flags", {rx_en, tx_en, pulses()}, 10'h000);
        check("R1 reset pointer", {9'd0, mr_sel}, 10'h000);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule